// File: doc/BRIEF.md
# Scaled PWM Clock Enable Generator

This block derives two slower clock enables from two base enable strobes that an upstream prescaler produces in the bus clock domain. Each of the two base strobes feeds its own path. In each path, an 8-bit down counter produces a tick once every N base strobes, where N is the programmed scale value. A toggle stage then halves that rate. The scaled enable is a one-cycle pulse on each rising transition of the toggle, so it always coincides with a base strobe. The scaled rate is therefore the base rate divided by 2·N, for any even divisor from 2 to 512.

Eight PWM channels each take one enable from this block. Each channel has one select bit, which picks either its family's base strobe or that family's scaled enable. The family is fixed by the channel index. A scale write reloads its counter at once, so a new rate takes effect without waiting for the old count to run out.

Top module: `pwm_scl_gen`

## Requirements
- R1: After reset, both counters and both toggles are zero. With no scale write, the first scaled pulse of a path comes on the 256th base strobe after reset, and every output is 0 while reset is held.
- R2: With select bit i at 0, ch_en_o[i] equals the base strobe of channel i's family. Channels whose index has bit 1 clear (0, 1, 4, 5) use family A. Channels with bit 1 set (2, 3, 6, 7) use family B.
- R3: With select bit i at 1, ch_en_o[i] equals the scaled enable of channel i's family.
- R4: A counter ticks once every N counted base strobes, where N is the scale value. A scale of 0 means N = 256.
- R5: The scaled enable fires on every second counter tick, namely the ticks that raise the toggle. It is a single-cycle pulse, so two scaled pulses are never in adjacent cycles.
- R6: Consecutive scaled pulses are 2·N base strobes apart. With a base strobe every 4 cycles, scale 0xFF gives 2040 cycles and scale 0x01 gives 8 cycles.
- R7: A scale write loads the new value into the counter in that cycle. The next tick comes after N further base strobes, and the toggle is left unchanged.
- R8: A base strobe in the same cycle as a scale write on the same path is not counted and produces no tick and no scaled pulse.
- R9: Paths A and B are independent. Strobes or writes on one path never change the other path's timing.
- R10: A channel enable is asserted only in a cycle where its family's base strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_a_en_i | input | 1 | Base strobe, family A |
| clk_b_en_i | input | 1 | Base strobe, family B |
| scale_a_i | input | 8 | Scale value, family A (0 means 256) |
| scale_a_wr_i | input | 1 | Write strobe for scale A; reloads counter A |
| scale_b_i | input | 8 | Scale value, family B (0 means 256) |
| scale_b_wr_i | input | 1 | Write strobe for scale B; reloads counter B |
| sel_i | input | 8 | Per-channel select: 0 base strobe, 1 scaled enable |
| ch_en_o | output | 8 | Per-channel clock enable |

## Verification
The assertions assume the following about the inputs:
- Each base strobe is a synchronous level sampled on every bus clock edge.
- The scale value is valid in the cycle its write strobe is high.
- The scale value is held between writes, because every counter reload reads it.

The stimulus drives all inputs only on the falling edge, so they are stable around each rising edge. It changes a scale value only together with its write strobe, and it mixes in writes that coincide with strobes, to reach the priority case from R8.

// File: rtl/pwm_scl_pkg.sv
package pwm_scl_pkg;
  localparam int unsigned SCL_W   = 8;
  localparam int unsigned NUM_CH  = 8;
  localparam int unsigned NUM_FAM = 2;

  typedef enum logic {
    FAM_A = 1'b0,
    FAM_B = 1'b1
  } fam_e;

  // channel pairs alternate families: index bit 1 picks B
  function automatic int unsigned fam_idx(int unsigned ch);
    return (ch / 2) % 2;
  endfunction
endpackage

// File: rtl/pwm_scl_div.sv
module pwm_scl_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic         wr_i,
  input  logic [W-1:0] scale_i,
  output logic         tick_o,
  output logic         scl_en_o
);
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         tog_q;
  logic         hit;

  // write wins over a coincident strobe
  assign hit = strobe_i & ~wr_i & (cnt_q == CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      if (wr_i) begin
        cnt_q <= scale_i;
      end else if (strobe_i) begin
        // zero wraps to all-ones: scale 0 acts as 2**W
        cnt_q <= hit ? scale_i : cnt_q - CNT_ONE;
      end
      if (hit) tog_q <= ~tog_q;
    end
  end

  assign tick_o   = hit;
  assign scl_en_o = hit & ~tog_q;
endmodule

// File: rtl/pwm_scl_sel.sv
module pwm_scl_sel
  import pwm_scl_pkg::*;
#(
  parameter int unsigned N_CH  = NUM_CH,
  parameter int unsigned N_FAM = NUM_FAM
) (
  input  logic [N_FAM-1:0] base_en_i,
  input  logic [N_FAM-1:0] scl_en_i,
  input  logic [N_CH-1:0]  sel_i,
  output logic [N_CH-1:0]  ch_en_o
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned FAM = fam_idx(ch);
    assign ch_en_o[ch] = sel_i[ch] ? scl_en_i[FAM] : base_en_i[FAM];
  end
endmodule

// File: rtl/pwm_scl_gen.sv
module pwm_scl_gen
  import pwm_scl_pkg::*;
#(
  parameter int unsigned W    = SCL_W,
  parameter int unsigned N_CH = NUM_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clk_a_en_i,
  input  logic            clk_b_en_i,
  input  logic [W-1:0]    scale_a_i,
  input  logic            scale_a_wr_i,
  input  logic [W-1:0]    scale_b_i,
  input  logic            scale_b_wr_i,
  input  logic [N_CH-1:0] sel_i,
  output logic [N_CH-1:0] ch_en_o
);
  localparam int unsigned N_FAM = NUM_FAM;

  logic [N_FAM-1:0] base_en, wr, tick, scl_en;
  logic [W-1:0]     scale [N_FAM];
  logic             sa_en, sb_en, tick_a, tick_b;

  assign base_en      = {clk_b_en_i, clk_a_en_i};
  assign wr           = {scale_b_wr_i, scale_a_wr_i};
  assign scale[FAM_A] = scale_a_i;
  assign scale[FAM_B] = scale_b_i;

  for (genvar f = 0; f < N_FAM; f++) begin : g_path
    pwm_scl_div #(.W(W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (base_en[f]),
      .wr_i     (wr[f]),
      .scale_i  (scale[f]),
      .tick_o   (tick[f]),
      .scl_en_o (scl_en[f])
    );
  end

  assign sa_en  = scl_en[FAM_A];
  assign sb_en  = scl_en[FAM_B];
  assign tick_a = tick[FAM_A];
  assign tick_b = tick[FAM_B];

  pwm_scl_sel #(.N_CH(N_CH), .N_FAM(N_FAM)) u_sel (
    .base_en_i (base_en),
    .scl_en_i  (scl_en),
    .sel_i     (sel_i),
    .ch_en_o   (ch_en_o)
  );
endmodule

// File: rtl/pwm_scl_gen_chk.sv
module pwm_scl_gen_chk
  import pwm_scl_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clk_a_en_i,
  input logic            clk_b_en_i,
  input logic            scale_a_wr_i,
  input logic            scale_b_wr_i,
  input logic [N_CH-1:0] ch_en_o,
  input logic            sa_en,
  input logic            sb_en,
  input logic            tick_a,
  input logic            tick_b
);
  a_r8_wr_blocks_tick_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_a_wr_i |-> !tick_a);
  a_r8_wr_blocks_tick_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_b_wr_i |-> !tick_b);

  a_r5_sa_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_en |-> tick_a);
  a_r5_sb_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_en |-> tick_b);
  a_r5_sa_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_en |=> !sa_en);
  a_r5_sb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sb_en |=> !sb_en);

  a_r10_tick_a_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_a |-> clk_a_en_i);
  a_r10_tick_b_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_b |-> clk_b_en_i);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned FAM = fam_idx(ch);
    if (FAM == 0) begin : g_a
      a_r10_ch_needs_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_en_o[ch] |-> clk_a_en_i);
    end else begin : g_b
      a_r10_ch_needs_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_en_o[ch] |-> clk_b_en_i);
    end
  end
endmodule

bind pwm_scl_gen pwm_scl_gen_chk #(.N_CH(N_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_a_en_i   (clk_a_en_i),
  .clk_b_en_i   (clk_b_en_i),
  .scale_a_wr_i (scale_a_wr_i),
  .scale_b_wr_i (scale_b_wr_i),
  .ch_en_o      (ch_en_o),
  .sa_en        (sa_en),
  .sb_en        (sb_en),
  .tick_a       (tick_a),
  .tick_b       (tick_b)
);

// File: tb/pwm_scl_gen_test.sv
module pwm_scl_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_en, b_en, wa, wb;
  logic [7:0] sa_val, sb_val, sel;
  logic [7:0] ch_en;

  always #5 clk = ~clk;

  pwm_scl_gen uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clk_a_en_i   (a_en),
    .clk_b_en_i   (b_en),
    .scale_a_i    (sa_val),
    .scale_a_wr_i (wa),
    .scale_b_i    (sb_val),
    .scale_b_wr_i (wb),
    .sel_i        (sel),
    .ch_en_o      (ch_en)
  );

  int checks = 0, fails = 0, cyc = 0, cyc0 = 0;
  int left_q [2];
  bit ph_q   [2];
  int last_p [8];
  int ival   [8];
  int npulse [8];

  function automatic int nval(logic [7:0] s);
    return (s == 8'd0) ? 256 : int'(s);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_track();
    cyc0 = cyc;
    for (int i = 0; i < 8; i++) begin
      last_p[i] = -1; ival[i] = 0; npulse[i] = 0;
    end
  endtask

  // inputs applied after negedge, outputs compared before posedge
  task automatic step(logic a, logic b, logic w_a, logic w_b, string ph);
    logic [1:0] base, scl, wr;
    a_en = a; b_en = b; wa = w_a; wb = w_b;
    #1;
    base = {b, a};
    wr   = {w_b, w_a};
    for (int p = 0; p < 2; p++)
      scl[p] = base[p] && !wr[p] && (left_q[p] == 1) && !ph_q[p];
    for (int i = 0; i < 8; i++) begin
      int  f;
      logic e;
      f = (i / 2) % 2;
      e = sel[i] ? scl[f] : base[f];
      if (ch_en[i] !== e)
        chk(1'b0, $sformatf("%s %s ch%0d", sel[i] ? "R3" : "R2", ph, i), int'(ch_en[i]), int'(e));
      else
        checks++;
      if (ch_en[i] === 1'b1) begin
        chk(base[f] == 1'b1, $sformatf("R10 %s ch%0d", ph, i), int'(base[f]), 1);
        if (last_p[i] >= 0) ival[i] = cyc - last_p[i];
        last_p[i] = cyc;
        npulse[i]++;
      end
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++) begin
      logic [7:0] sv;
      sv = (p == 0) ? sa_val : sb_val;
      if (wr[p]) left_q[p] = nval(sv);
      else if (base[p]) begin
        if (left_q[p] == 1) begin
          left_q[p] = nval(sv);
          ph_q[p]   = ~ph_q[p];
        end else left_q[p]--;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_en = 0; b_en = 0; wa = 0; wb = 0;
    sa_val = 8'd0; sb_val = 8'd0; sel = 8'h00;
    for (int p = 0; p < 2; p++) begin left_q[p] = 256; ph_q[p] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(ch_en == 8'h00, "R1 reset outputs", int'(ch_en), 0);
    sel = 8'hFF;
    #1;
    chk(ch_en == 8'h00, "R1 reset outputs sel", int'(ch_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: first scaled pulse on 256th strobe
    clear_track();
    repeat (256) step(1, 0, 0, 0, "T_rst");
    chk(npulse[0] == 1, "R1 pulse count", npulse[0], 1);
    chk(last_p[0] - cyc0 == 255, "R1 first pulse strobe index", last_p[0] - cyc0, 255);

    // R7/R8: write with coincident strobe, toggle kept high
    sa_val = 8'd3;
    clear_track();
    step(1, 0, 1, 0, "T_wr");
    repeat (6) step(1, 0, 0, 0, "T_wr");
    chk(npulse[0] == 1, "R7 pulse count after reload", npulse[0], 1);
    chk(last_p[0] - cyc0 == 6, "R8 strobe in write cycle not counted", last_p[0] - cyc0, 6);

    // R6: scale 0xFF, strobe every 4 cycles
    sa_val = 8'hFF;
    step(0, 0, 1, 0, "T_ff");
    clear_track();
    for (int k = 0; k < 6200; k++) step(k % 4 == 3, 0, 0, 0, "T_ff");
    chk(npulse[0] >= 2, "R6 pulses at scale 0xFF", npulse[0], 2);
    chk(ival[0] == 2040, "R6 interval scale 0xFF", ival[0], 2040);

    // R5/R6: scale 1, strobe every 4 cycles
    sa_val = 8'd1;
    step(0, 0, 1, 0, "T_one");
    clear_track();
    for (int k = 0; k < 40; k++) step(k % 4 == 3, 0, 0, 0, "T_one");
    chk(npulse[0] >= 4, "R5 pulses at scale 1", npulse[0], 4);
    chk(ival[0] == 8, "R6 interval scale 1", ival[0], 8);

    // R4: scale 0 means 256
    sa_val = 8'd0;
    step(0, 0, 1, 0, "T_zero");
    clear_track();
    repeat (1100) step(1, 0, 0, 0, "T_zero");
    chk(npulse[0] >= 2, "R4 pulses at scale 0", npulse[0], 2);
    chk(ival[0] == 512, "R4 interval scale 0", ival[0], 512);

    // R9: mixed selects, random strobes and writes on both paths
    sel = 8'hA5;
    sa_val = 8'd2; sb_val = 8'd5;
    step(0, 0, 1, 1, "R9_mix");
    for (int k = 0; k < 2000; k++) begin
      logic ra, rb, rwa, rwb;
      ra  = ($urandom % 2) == 0;
      rb  = ($urandom % 3) == 0;
      rwa = ($urandom % 60) == 0;
      rwb = ($urandom % 45) == 0;
      step(ra, rb, rwa, rwb, "R9_mix");
    end

    // R9: B path timing with A randomly active
    sb_val = 8'd2;
    step(0, 1, 0, 1, "R9_b");
    clear_track();
    for (int k = 0; k < 40; k++) step(($urandom % 2) == 0, 1, 0, 0, "R9_b");
    chk(ival[2] == 4, "R9 B interval scale 2", ival[2], 4);

    // R8: continuous writes suppress every scaled pulse
    sel = 8'hFF; sa_val = 8'd1;
    clear_track();
    repeat (20) step(1, 0, 1, 0, "R8_hold");
    chk(npulse[0] == 0, "R8 no pulse under writes", npulse[0], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule